// File: doc/BRIEF.md
# Triggered Sample Word Counter with Capture

This block keeps a running tally of audio words as they finish transferring. The tally is a 10-bit counter that steps by one on every cycle the word-complete strobe is high. When it reaches 1023 it rolls over to 0. A capture event writes a snapshot of the tally into a holding register and, in the same clock edge, sets the tally back to zero. Software can then read how many words moved between two events, such as two frame markers or two timer ticks.

There are two kinds of capture event. The first is a hardware event: three trigger lines come in (a bus start-of-frame marker, an external pin event and a timer channel event), and a 2-bit select field picks one of them, or none. The second is a bus write strobe to the count register. It captures every time, whatever the select field holds. A rising-edge detector watches each hardware line. The detector is a two-state machine with states `EDG_LOW` and `EDG_HIGH`. The transitions are RISE (LOW to HIGH while the line is high, which emits a one-cycle pulse) and DROP (HIGH to LOW while the line is low). The counter path picks one action each cycle: `ACT_HOLD`, `ACT_INC` or `ACT_SNAP`. The snapshot comes out as an 8-bit low part and a 2-bit high part.

Top module: `word_tally_capture`

## Requirements
- R1: Each rising clock edge with `word_done` high adds one to the internal 10-bit tally. With `word_done` low and no capture event, the tally keeps its value.
- R2: The tally wraps from 1023 to 0. Capturing after 1030 words gives 6, and capturing after 1024 words gives 0.
- R3: On a capture event, the capture register takes the tally plus one if `word_done` is high in that same cycle, and the tally becomes 0. The next word then counts as 1.
- R4: The `trig_sel` encoding is: 2'b00 means no hardware trigger, 2'b01 selects `trig_sof`, 2'b10 selects `trig_pin` and 2'b11 selects `trig_tmr`. Lines that are not selected have no effect on the capture.
- R5: A high `cnt_wr` causes a capture event in that cycle for every value of `trig_sel`. If it coincides with a hardware trigger, only one capture occurs.
- R6: A hardware trigger acts only on its low-to-high transition, judged at the clock. A line held high yields exactly one capture. Switching `trig_sel` onto a line that is already high causes no capture. Each line's edge state is tracked whether or not that line is selected. After reset every line counts as low.
- R7: `cap_lo` shows capture bits 7:0 and `cap_hi` shows capture bits 9:8. Both are 0 after reset.
- R8: Between capture events the capture outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| word_done | input | 1 | One audio word finished this cycle |
| trig_sof | input | 1 | Bus start-of-frame trigger line |
| trig_pin | input | 1 | External pin trigger line |
| trig_tmr | input | 1 | Timer channel trigger line |
| trig_sel | input | 2 | Hardware trigger select (00 none, 01 sof, 10 pin, 11 timer) |
| cnt_wr | input | 1 | Bus write strobe to the count register |
| cap_lo | output | 8 | Capture bits 7:0 |
| cap_hi | output | 2 | Capture bits 9:8 |

## Verification
The assertions assume that all inputs are synchronous to `clk` and hold a steady 0 or 1 at each rising edge. The edge detectors see the trigger lines only at clock edges, so a pulse shorter than one cycle is outside their model. The bench drives every input on the falling edge and holds it for a whole cycle. The random trigger lines stay high for several cycles at a time and fall back low, so they produce both held-level edges and fresh ones. This stays within what the edge-state assertions rely on.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    localparam int CNT_W  = 10;
    localparam int LO_W   = 8;
    localparam int HI_W   = CNT_W - LO_W;
    localparam int NUM_HW = 3;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        TSEL_SOFT = 2'b00,
        TSEL_SOF  = 2'b01,
        TSEL_PIN  = 2'b10,
        TSEL_TMR  = 2'b11
    } trig_sel_e;

    typedef enum logic {
        EDG_LOW  = 1'b0,
        EDG_HIGH = 1'b1
    } edge_st_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_INC  = 2'd1,
        ACT_SNAP = 2'd2
    } tally_act_e;
endpackage

// File: rtl/wtc_edge_fsm.sv
module wtc_edge_fsm
    import wtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    edge_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= EDG_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        rise = 1'b0;
        unique case (st_q)
            EDG_LOW: begin
                if (lvl) begin
                    st_d = EDG_HIGH;   // RISE
                    rise = 1'b1;
                end
            end
            EDG_HIGH: begin
                if (!lvl) st_d = EDG_LOW; // DROP
            end
            default: st_d = EDG_LOW;
        endcase
    end

    // R6: a pulse never repeats on the next cycle
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    // R6: a line that stays high gives no further pulse
    p_level_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl && $past(lvl)) |-> !rise);
endmodule

// File: rtl/wtc_trig_mux.sv
module wtc_trig_mux
    import wtc_pkg::*;
(
    input  logic [NUM_HW-1:0] rise_vec,
    input  logic [SEL_W-1:0]  sel,
    input  logic              sw_wr,
    output logic              snap
);
    logic hw_evt;

    always_comb begin
        hw_evt = 1'b0;
        unique case (trig_sel_e'(sel))
            TSEL_SOFT: hw_evt = 1'b0;
            TSEL_SOF:  hw_evt = rise_vec[0];
            TSEL_PIN:  hw_evt = rise_vec[1];
            TSEL_TMR:  hw_evt = rise_vec[2];
            default:   hw_evt = 1'b0;
        endcase
        snap = hw_evt | sw_wr;
    end
endmodule

// File: rtl/wtc_tally.sv
module wtc_tally
    import wtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_done,
    input  logic             snap,
    output logic [CNT_W-1:0] cap
);
    logic [CNT_W-1:0] cnt_q, cnt_d, cap_d, sum;
    tally_act_e act;

    assign sum = cnt_q + CNT_W'(word_done);

    always_comb begin
        if (snap)           act = ACT_SNAP;
        else if (word_done) act = ACT_INC;
        else                act = ACT_HOLD;
    end

    always_comb begin
        cnt_d = cnt_q;
        cap_d = cap;
        unique case (act)
            ACT_HOLD: cnt_d = cnt_q;
            ACT_INC:  cnt_d = sum;
            ACT_SNAP: begin
                cap_d = sum;
                cnt_d = '0;
            end
            default:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cap   <= '0;
        end else begin
            cnt_q <= cnt_d;
            cap   <= cap_d;
        end
    end

    // R1, R2: a step of one per word, modulo the counter width
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> cnt_q == $past(cnt_q) + CNT_W'($past(word_done)));
    // R3: a capture clears the tally
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> cnt_q == '0);
    // R3: the capture includes a coincident word
    p_snap_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> cap == $past(cnt_q) + CNT_W'($past(word_done)));
    // R8: the capture holds without an event
    p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(cap));
endmodule

// File: rtl/word_tally_capture.sv
module word_tally_capture
    import wtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            word_done,
    input  logic            trig_sof,
    input  logic            trig_pin,
    input  logic            trig_tmr,
    input  logic [SEL_W-1:0] trig_sel,
    input  logic            cnt_wr,
    output logic [LO_W-1:0] cap_lo,
    output logic [HI_W-1:0] cap_hi
);
    logic [NUM_HW-1:0] lines, rises;
    logic              snap;
    logic [CNT_W-1:0]  cap;

    assign lines = {trig_tmr, trig_pin, trig_sof};

    for (genvar g = 0; g < NUM_HW; g++) begin : g_edge
        wtc_edge_fsm u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (lines[g]),
            .rise (rises[g])
        );
    end

    wtc_trig_mux u_mux (
        .rise_vec(rises),
        .sel     (trig_sel),
        .sw_wr   (cnt_wr),
        .snap    (snap)
    );

    wtc_tally u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_done(word_done),
        .snap     (snap),
        .cap      (cap)
    );

    assign cap_lo = cap[LO_W-1:0];
    assign cap_hi = cap[CNT_W-1:LO_W];

    // R4: with no hardware trigger selected and no write, the outputs hold
    p_soft_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel == TSEL_SOFT && !cnt_wr) |=> ($stable(cap_lo) && $stable(cap_hi)));
    // R6: a line already high while selected cannot cause a capture
    p_held_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel == TSEL_PIN && trig_pin && $past(trig_pin) && !cnt_wr)
        |=> ($stable(cap_lo) && $stable(cap_hi)));
endmodule

// File: tb/word_tally_capture_bench.sv
`timescale 1ns/1ps
module word_tally_capture_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       word_done = 1'b0;
    logic       trig_sof = 1'b0, trig_pin = 1'b0, trig_tmr = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic       cnt_wr = 1'b0;
    logic [7:0] cap_lo;
    logic [1:0] cap_hi;

    int checks = 0;
    int fails = 0;

    logic [9:0] m_cnt = '0;
    logic [9:0] m_cap = '0;
    logic [2:0] m_prev = '0;

    always #2 clk = ~clk;

    word_tally_capture u_word_tally_capture (
        .clk(clk), .rst_n(rst_n), .word_done(word_done),
        .trig_sof(trig_sof), .trig_pin(trig_pin), .trig_tmr(trig_tmr),
        .trig_sel(trig_sel), .cnt_wr(cnt_wr),
        .cap_lo(cap_lo), .cap_hi(cap_hi)
    );

    // Selected hardware edge, per R4 encoding (bit0 sof, bit1 pin, bit2 tmr)
    function automatic logic pick_hw(input logic [2:0] r, input logic [1:0] s);
        case (s)
            2'b01:   return r[0];
            2'b10:   return r[1];
            2'b11:   return r[2];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [9:0] add_word(input logic [9:0] c, input logic w);
        return c + {9'd0, w};
    endfunction

    task automatic check_cap(input string tag, input logic [9:0] exp);
        checks++;
        if ({cap_hi, cap_lo} !== exp) begin
            fails++;
            $display("FAIL %s cap=%0d exp=%0d", tag, {cap_hi, cap_lo}, exp);
        end
    endtask

    task automatic cyc(input logic wd, input logic [2:0] tr, input logic [1:0] sel,
                       input logic wr, input string tag);
        logic [2:0] rs;
        logic [9:0] s;
        @(negedge clk);
        word_done = wd;
        {trig_tmr, trig_pin, trig_sof} = tr;
        trig_sel = sel;
        cnt_wr = wr;
        @(posedge clk);
        #1;
        rs = tr & ~m_prev;
        m_prev = tr;
        s = add_word(m_cnt, wd);
        if (pick_hw(rs, sel) || wr) begin
            m_cap = s;
            m_cnt = '0;
        end else begin
            m_cnt = s;
        end
        check_cap(tag, m_cap);
    endtask

    task automatic words(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 3'b000, 2'b00, 1'b0, tag);
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [2:0] tr;
        int hold;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_cap("R7 reset", 10'd0);

        // R1, R5: five words then a software write with select 00
        words(5, "R1");
        cyc(1'b0, 3'b000, 2'b00, 1'b1, "R5 sw capture");
        check_cap("R1 count of 5", 10'd5);
        // R5: the write captures under every select value
        words(3, "R1");
        cyc(1'b0, 3'b000, 2'b11, 1'b1, "R5 sel 11");
        check_cap("R5 write with sel 11", 10'd3);

        // R3: a coincident word is included, then the tally restarts
        words(2, "R1");
        cyc(1'b1, 3'b000, 2'b00, 1'b1, "R3 coincident");
        check_cap("R3 includes word", 10'd3);
        cyc(1'b1, 3'b000, 2'b00, 1'b1, "R3 restart");
        check_cap("R3 restart at 1", 10'd1);

        // R2: wrap; 1023 words, then 1030, then 1024
        words(1023, "R2");
        cyc(1'b0, 3'b000, 2'b00, 1'b1, "R2 max");
        check_cap("R2 hi=3 lo=ff (R7 split)", 10'd1023);
        words(1030, "R2");
        cyc(1'b0, 3'b000, 2'b00, 1'b1, "R2 wrap");
        check_cap("R2 wrap 1030", 10'd6);
        words(1024, "R2");
        cyc(1'b0, 3'b000, 2'b00, 1'b1, "R2 wrap");
        check_cap("R2 wrap 1024", 10'd0);

        // R4: each select picks only its line; others ignored
        words(4, "R1");
        cyc(1'b0, 3'b110, 2'b01, 1'b0, "R4 unselected ignored");
        cyc(1'b0, 3'b000, 2'b01, 1'b0, "R4 idle");
        cyc(1'b0, 3'b001, 2'b01, 1'b0, "R4 sof selected");
        check_cap("R4 sof", 10'd4);
        words(7, "R1");
        cyc(1'b0, 3'b010, 2'b10, 1'b0, "R4 pin selected");
        check_cap("R4 pin", 10'd7);
        words(9, "R1");
        cyc(1'b0, 3'b100, 2'b11, 1'b0, "R4 tmr selected");
        check_cap("R4 tmr", 10'd9);
        cyc(1'b0, 3'b000, 2'b00, 1'b0, "R4 idle");
        words(2, "R1");
        cyc(1'b0, 3'b111, 2'b00, 1'b0, "R4 sel 00 ignores edges");
        check_cap("R4 sel 00", 10'd9);

        // R6: held high gives one capture; switching select onto a high line does nothing
        cyc(1'b0, 3'b000, 2'b00, 1'b1, "R5 clear");
        words(3, "R1");
        cyc(1'b1, 3'b010, 2'b10, 1'b0, "R6 first edge");
        check_cap("R6 edge", 10'd4);
        for (int i = 0; i < 6; i++) cyc(1'b1, 3'b010, 2'b10, 1'b0, "R6 held");
        check_cap("R6 held no recapture", 10'd4);
        cyc(1'b1, 3'b011, 2'b10, 1'b0, "R6 sof rises unselected");
        cyc(1'b1, 3'b011, 2'b01, 1'b0, "R6 switch onto high line");
        check_cap("R6 switch no capture", 10'd4);
        cyc(1'b0, 3'b000, 2'b01, 1'b0, "R8 drop");
        cyc(1'b0, 3'b001, 2'b01, 1'b1, "R5 write plus edge");
        check_cap("R5 single capture", 10'd8);

        // Random mix with fixed seed
        void'($urandom(32'd20240611));
        tr = 3'b000;
        hold = 0;
        for (int i = 0; i < 6000; i++) begin
            if (hold == 0) begin
                tr = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
                hold = 1 + ($urandom % 5);
            end
            hold--;
            cyc(1'($urandom % 3 != 0), tr, 2'($urandom), ($urandom % 40) == 0,
                "R8 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule